// File: doc/BRIEF.md
# Daisy-Chain ADC Readback Master

This block sits on the host side of a string of serial successive-approximation converters that share one convert line and one serial clock. The converters are wired in a chain: the data output of each feeds the data input of the next, and the input of the converter farthest from the host is tied low. The host sees only the data output of the converter nearest to it. On a start request the block raises the convert line while the serial clock is low, holds it high for a fixed conversion time, and then issues one clock burst long enough to carry every converter's frame through the chain. The convert line stays high for the whole burst.

Each converter's frame is an 18-bit result, or 24 bits when a six-bit status word is appended. The block samples the chain output on each rising serial-clock edge and collects one continuous stream, most significant bit first. When the last bit is in, it drops the convert line and presents all per-converter words at once with a one-cycle valid strobe. The conversion wait and the serial-clock half period are parameters, and the serial clock rests low between bursts.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset, cnv_o, sck_o and valid_o are low and words_o is all zeros.
- R2: A start_i pulse while idle raises cnv_o on the next clock edge with sck_o low.
- R3: The first rising edge of sck_o comes CONV_CYC + SCK_HALF clock cycles after cnv_o rises, and each high and each low phase of sck_o lasts SCK_HALF clock cycles.
- R4: A burst has exactly 18 × N_DEV rising sck_o edges when status is off, and 24 × N_DEV when status is on, so cnv_o stays high for CONV_CYC + 2·SCK_HALF·(bits) cycles.
- R5: sdo_i is sampled on the clock edge that raises sck_o, and the first sampled bit is the most significant bit of a frame.
- R6: The first frame in the stream comes from the converter nearest the host and is placed in slot 0, words_o[WORD_W-1:0]. Slot k occupies words_o[k·WORD_W +: WORD_W], with WORD_W = 24.
- R7: With status on, a slot holds the result in bits [23:6] and the status in bits [5:0]. With status off, the result is in bits [17:0] and bits [23:18] are zero.
- R8: cnv_o falls on the same clock edge as the last falling edge of sck_o. valid_o is high for exactly that one following cycle, and words_o holds its value until the next burst completes.
- R9: start_i and status_en_i are ignored while a conversion or burst is in progress. status_en_i only counts at the accepted start.
- R10: sck_o is low whenever cnv_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion and readback |
| status_en_i | input | 1 | Converters append a six-bit status word (sampled at start) |
| sdo_i | input | 1 | Serial data from the nearest converter |
| cnv_o | output | 1 | Shared convert line |
| sck_o | output | 1 | Shared serial clock |
| valid_o | output | 1 | One-cycle strobe: words_o updated |
| words_o | output | N_DEV*24 | Per-converter words, slot 0 = nearest |

## Verification
The assertions assume that status_en_i matches the converters' real configuration and that sdo_i changes only after a falling sck_o edge, so that the bit count is fixed by the status setting captured at the start. The bench meets these assumptions with a chain model. It loads the whole stream when cnv_o rises and shifts one bit after each observed falling edge. It feeds zeros after the end of the stream, the same as the tied-low input at the far end. Random words and status values are mixed with all-zero, all-one and alternating patterns, and some start pulses are sent in the middle of a burst with the status setting flipped.

// File: rtl/adc_chain_pkg.sv
// Shared types for the daisy-chain ADC readback master.
// Assumes nothing beyond IEEE 1800-2017.
package adc_chain_pkg;

    // Sequencer phases: idle, conversion wait, clock burst.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CONV = 2'd1,
        SEQ_XFER = 2'd2
    } seq_state_t;

    localparam int RESULT_BITS = 18;
    localparam int STATUS_BITS = 6;

endpackage

// File: rtl/adc_sck_timer.sv
// Serial clock generator: while run_i is high it toggles sck_o every
// SCK_HALF system cycles, starting low. It flags the edge that raises sck_o
// (rise_o) and the edge that lowers it (fall_o). When run_i is low, sck_o
// is held low. Assumes SCK_HALF >= 1.
module adc_sck_timer #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HCW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [HCW-1:0] HC_LAST = HCW'(SCK_HALF - 1);

    logic [HCW-1:0] half_cnt;
    logic           sck_q;
    logic           phase_end;

    // Marks the last system cycle of the current half period.
    assign phase_end = run_i && (half_cnt == HC_LAST);
    assign rise_o    = phase_end && !sck_q;
    assign fall_o    = phase_end && sck_q;
    assign sck_o     = sck_q;

    // Counts out half periods and toggles the clock at their end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            sck_q    <= 1'b0;
        end else if (!run_i) begin
            half_cnt <= '0;
            sck_q    <= 1'b0;
        end else if (phase_end) begin
            half_cnt <= '0;
            sck_q    <= ~sck_q;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Sequencer: accepts a start while idle, raises the convert line, waits
// CONV_CYC cycles, runs the serial clock for the number of bits that the
// status setting captured at start calls for, then drops the convert line
// and strobes valid. Assumes CONV_CYC >= 1.
module adc_seq_ctrl
    import adc_chain_pkg::*;
#(
    parameter int N_DEV    = 2,
    parameter int CONV_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic status_en_i,
    input  logic fall_i,
    output logic run_o,
    output logic load_o,
    output logic capture_o,
    output logic stat_o,
    output logic cnv_o,
    output logic valid_o
);
    localparam int TOT_PLAIN = N_DEV * RESULT_BITS;
    localparam int TOT_STAT  = N_DEV * (RESULT_BITS + STATUS_BITS);
    localparam int BCW       = $clog2(TOT_STAT + 1);
    localparam int CCW       = $clog2(CONV_CYC + 1);

    seq_state_t     state_q;
    logic [CCW-1:0] conv_cnt;
    logic [BCW-1:0] bit_cnt;
    logic [BCW-1:0] last_idx;
    logic           stat_q;
    logic           cnv_q;
    logic           valid_q;
    logic           last_bit;

    // Index of the final bit, chosen by the status setting captured at start.
    assign last_idx  = stat_q ? BCW'(TOT_STAT - 1) : BCW'(TOT_PLAIN - 1);
    assign last_bit  = (bit_cnt == last_idx);
    assign run_o     = (state_q == SEQ_XFER);
    assign load_o    = (state_q == SEQ_IDLE) && start_i;
    assign capture_o = run_o && fall_i && last_bit;
    assign stat_o    = stat_q;
    assign cnv_o     = cnv_q;
    assign valid_o   = valid_q;

    // Phase sequencing, convert line and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            conv_cnt <= '0;
            bit_cnt  <= '0;
            stat_q   <= 1'b0;
            cnv_q    <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q  <= SEQ_CONV;
                        cnv_q    <= 1'b1;
                        conv_cnt <= CCW'(CONV_CYC - 1);
                        stat_q   <= status_en_i;
                        bit_cnt  <= '0;
                    end
                end
                SEQ_CONV: begin
                    if (conv_cnt == '0) begin
                        state_q <= SEQ_XFER;
                    end else begin
                        conv_cnt <= conv_cnt - 1'b1;
                    end
                end
                SEQ_XFER: begin
                    if (fall_i) begin
                        if (last_bit) begin
                            state_q <= SEQ_IDLE;
                            cnv_q   <= 1'b0;
                            valid_q <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnv_q   <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_frame_shifter.sv
// Stream collector: shifts sdo_i in on each raising sck edge, MSB first,
// then on capture splits the stream into one WORD_W slot per converter,
// nearest converter in slot 0. Assumes exactly the burst's bit count is
// shifted in between load and capture.
module adc_frame_shifter
    import adc_chain_pkg::*;
#(
    parameter int N_DEV = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       load_i,
    input  logic                                       rise_i,
    input  logic                                       capture_i,
    input  logic                                       stat_i,
    input  logic                                       sdo_i,
    output logic [N_DEV*(RESULT_BITS+STATUS_BITS)-1:0] words_o
);
    localparam int WORD_W = RESULT_BITS + STATUS_BITS;
    localparam int SHW    = N_DEV * WORD_W;

    logic [SHW-1:0] shreg;
    logic [SHW-1:0] slots_n;
    logic [SHW-1:0] words_q;

    // Slot k takes the k-th frame of the stream, counted from the earliest.
    for (genvar k = 0; k < N_DEV; k++) begin : g_slot
        assign slots_n[k*WORD_W +: WORD_W] = stat_i
            ? shreg[(N_DEV-1-k)*WORD_W +: WORD_W]
            : {{STATUS_BITS{1'b0}}, shreg[(N_DEV-1-k)*RESULT_BITS +: RESULT_BITS]};
    end

    // Serial capture of the chain output.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            shreg <= '0;
        end else if (rise_i) begin
            shreg <= {shreg[SHW-2:0], sdo_i};
        end
    end

    // Holds the unpacked words from one completion to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else if (capture_i) begin
            words_q <= slots_n;
        end
    end

    assign words_o = words_q;
endmodule

// File: rtl/adc_chain_reader.sv
// Top level of the daisy-chain ADC readback master. It ties together the
// sequencer, serial clock generator and stream collector. Assumes the
// converters are set up for chained readout and that status_en_i matches
// their status-word setting.
module adc_chain_reader #(
    parameter int N_DEV    = 2,
    parameter int CONV_CYC = 40,
    parameter int SCK_HALF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            status_en_i,
    input  logic            sdo_i,
    output logic            cnv_o,
    output logic            sck_o,
    output logic            valid_o,
    output logic [N_DEV*24-1:0] words_o
);
    logic run;
    logic load;
    logic capture;
    logic stat;
    logic rise;
    logic fall;

    adc_seq_ctrl #(
        .N_DEV   (N_DEV),
        .CONV_CYC(CONV_CYC)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .status_en_i(status_en_i),
        .fall_i     (fall),
        .run_o      (run),
        .load_o     (load),
        .capture_o  (capture),
        .stat_o     (stat),
        .cnv_o      (cnv_o),
        .valid_o    (valid_o)
    );

    adc_sck_timer #(
        .SCK_HALF(SCK_HALF)
    ) sck_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .sck_o (sck_o),
        .rise_o(rise),
        .fall_o(fall)
    );

    adc_frame_shifter #(
        .N_DEV(N_DEV)
    ) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .rise_i   (rise),
        .capture_i(capture),
        .stat_i   (stat),
        .sdo_i    (sdo_i),
        .words_o  (words_o)
    );
endmodule

// File: rtl/adc_chain_reader_chk.sv
// Protocol checker for adc_chain_reader, attached by bind. It watches only
// the top-level ports and keeps its own count of serial clock edges.
module adc_chain_reader_chk #(
    parameter int N_DEV    = 2,
    parameter int CONV_CYC = 40,
    parameter int SCK_HALF = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic status_en_i,
    input logic cnv_o,
    input logic sck_o,
    input logic valid_o
);
    logic [15:0] rise_cnt;
    logic        sck_prev;
    logic        stat_ck;

    // Counts rising serial clock edges per burst and records the status setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            sck_prev <= 1'b0;
            stat_ck  <= 1'b0;
        end else begin
            sck_prev <= sck_o;
            if (start_i && !cnv_o) begin
                rise_cnt <= '0;
                stat_ck  <= status_en_i;
            end else if (sck_o && !sck_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    a_r2_cnv_rises_with_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> !sck_o);

    a_r10_sck_only_under_cnv: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_o |-> !sck_o);

    a_r8_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r8_valid_after_cnv_fall: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!cnv_o && $past(cnv_o)));

    a_r4_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (rise_cnt == (stat_ck ? 16'(N_DEV * 24) : 16'(N_DEV * 18))));

    a_r9_busy_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o && start_i) |=> (cnv_o || valid_o));
endmodule

bind adc_chain_reader adc_chain_reader_chk #(
    .N_DEV   (N_DEV),
    .CONV_CYC(CONV_CYC),
    .SCK_HALF(SCK_HALF)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .status_en_i(status_en_i),
    .cnv_o      (cnv_o),
    .sck_o      (sck_o),
    .valid_o    (valid_o)
);

// File: tb/adc_chain_reader_tb_top.sv
// Bench for adc_chain_reader. It models the converter chain as one shift
// register that is loaded when cnv_o rises and shifted after each falling
// sck_o edge.
module adc_chain_reader_tb_top;
    localparam int N    = 3;
    localparam int CONV = 10;
    localparam int HALF = 2;
    localparam int WW   = 24;
    localparam int MAXB = N * WW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic status_en_i = 1'b0;
    logic sdo_i;
    logic cnv_o, sck_o, valid_o;
    logic [N*WW-1:0] words_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [17:0] dev_data [N];
    logic [5:0]  dev_stat [N];
    logic [MAXB-1:0] pending;
    logic [MAXB-1:0] chain_q = '0;

    logic cnv_prev = 1'b0, sck_prev = 1'b0, seen_rise = 1'b0, sck_at_cnv_rise = 1'b0;
    int cnv_hi = 0, rises = 0, lat = 0, valid_cnt = 0;

    adc_chain_reader #(.N_DEV(N), .CONV_CYC(CONV), .SCK_HALF(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_en_i(status_en_i),
        .sdo_i(sdo_i), .cnv_o(cnv_o), .sck_o(sck_o), .valid_o(valid_o),
        .words_o(words_o)
    );

    always #5 clk = ~clk;
    assign sdo_i = chain_q[MAXB-1];

    // Chain model and edge bookkeeping, sampled away from the active edge.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cnv_o && !cnv_prev) begin
            chain_q <= pending;
            cnv_hi = 1; rises = 0; seen_rise = 1'b0;
            sck_at_cnv_rise = sck_o;
        end else if (cnv_o) begin
            cnv_hi = cnv_hi + 1;
        end
        if (!sck_o && sck_prev) chain_q <= {chain_q[MAXB-2:0], 1'b0};
        if (sck_o && !sck_prev) begin
            rises = rises + 1;
            if (!seen_rise) begin lat = cnv_hi - 1; seen_rise = 1'b1; end
        end
        if (valid_o) valid_cnt = valid_cnt + 1;
        cnv_prev = cnv_o;
        sck_prev = sck_o;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MAXB-1:0] build_stream(input bit st);
        logic [MAXB-1:0] s = '0;
        int pos = MAXB;
        for (int k = 0; k < N; k++) begin
            for (int b = 17; b >= 0; b--) begin pos--; s[pos] = dev_data[k][b]; end
            if (st) for (int b = 5; b >= 0; b--) begin pos--; s[pos] = dev_stat[k][b]; end
        end
        return s;
    endfunction

    function automatic logic [WW-1:0] exp_word(input int k, input bit st);
        return st ? {dev_data[k], dev_stat[k]} : {6'b0, dev_data[k]};
    endfunction

    // One full start / conversion / burst / completion, with optional busy start.
    task automatic run_frame(input bit st, input bit poke);
        int bits = N * (st ? 24 : 18);
        int wait_cyc = 0;
        pending = build_stream(st);
        valid_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; status_en_i = st;
        @(negedge clk);
        start_i = 1'b0; status_en_i = 1'($urandom);
        check("R2 cnv high after start", 64'(cnv_o), 64'd1);
        check("R2 sck low at cnv rise", 64'(sck_at_cnv_rise), 64'd0);
        while (!valid_o && wait_cyc < 5000) begin
            if (poke && wait_cyc == CONV + 20) begin start_i = 1'b1; status_en_i = ~st; end
            else start_i = 1'b0;
            @(negedge clk);
            wait_cyc++;
        end
        start_i = 1'b0;
        check("R8 burst completed", 64'(valid_o), 64'd1);
        check("R8 cnv low at valid", 64'(cnv_o), 64'd0);
        check("R4 rising edge count", 64'(rises), 64'(bits));
        check("R4 cnv high width", 64'(cnv_hi), 64'(CONV + 2 * HALF * bits));
        check("R3 first rise latency", 64'(lat), 64'(CONV + HALF));
        for (int k = 0; k < N; k++) begin
            check(st ? "R7 R6 R5 slot with status" : "R7 R6 R5 slot plain",
                  64'(words_o[k*WW +: WW]), 64'(exp_word(k, st)));
        end
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R8 valid single cycle", 64'(valid_cnt), 64'd1);
        check(poke ? "R9 busy start ignored" : "R10 idle after burst",
              64'({cnv_o, sck_o}), 64'd0);
        for (int k = 0; k < N; k++)
            check("R8 words held", 64'(words_o[k*WW +: WW]), 64'(exp_word(k, st)));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset outputs", 64'({cnv_o, sck_o, valid_o}), 64'd0);
        check("R1 reset words", 64'(words_o), 64'd0);
        // Idle with no start: no clocks, no convert.
        repeat (10) @(negedge clk);
        check("R10 quiet while idle", 64'({cnv_o, sck_o, valid_o}), 64'd0);

        for (int k = 0; k < N; k++) begin dev_data[k] = '0; dev_stat[k] = '0; end
        run_frame(1'b0, 1'b0);
        for (int k = 0; k < N; k++) begin dev_data[k] = '1; dev_stat[k] = '1; end
        run_frame(1'b1, 1'b0);
        run_frame(1'b0, 1'b0);
        for (int k = 0; k < N; k++) begin dev_data[k] = 18'h2AAAA; dev_stat[k] = 6'h15; end
        run_frame(1'b1, 1'b1);
        for (int k = 0; k < N; k++) begin dev_data[k] = 18'h1 << k; dev_stat[k] = 6'h20 >> k; end
        run_frame(1'b1, 1'b0);
        run_frame(1'b0, 1'b1);

        for (int t = 0; t < 30; t++) begin
            for (int k = 0; k < N; k++) begin
                dev_data[k] = 18'($urandom);
                dev_stat[k] = 6'($urandom);
            end
            run_frame(1'($urandom), ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule